// File: doc/BRIEF.md
# 8-bit ALU with flags

This block is the arithmetic and logic unit of a small 8-bit processor. It takes two operands, a 4-bit operation code and the current carry and half-carry flags. It returns an 8-bit result and the next negative (N), overflow (V), half-carry (H), zero (Z) and carry (C) flags.

The result and each flag come with their own write-enable. The register file around the block writes back only what the operation is meant to change. The block is purely combinational. Operand fetch, decode and register storage are done elsewhere.

Operation codes on `op`:

| Code | Operation |
|------|-----------|
| 0 | add with carry |
| 1 | subtract with borrow |
| 2 | compare |
| 3 | AND |
| 4 | OR |
| 5 | XOR |
| 6 | shift left |
| 7 | shift right |
| 8 | rotate left through carry |
| 9 | rotate right through carry |
| 10 | increment |
| 11 | decrement |
| 12 | nibble swap |
| 13 | decimal adjust after add |
| 14 | decimal adjust after subtract |
| 15 | no operation |

Single-operand operations (codes 6 to 14) work on `a_in` alone.

Top module: `alu8_flags`

## Requirements
- R1: For op 0, `{c, y}` equals `a_in + b_in + c_in` as a 9-bit sum, so C is set when the sum reaches 0x100.
- R2: For op 0, V is set when `a_in` and `b_in` share bit 7 and `y[7]` differs from it. H is bit 4 of `a_in ^ b_in ^ y`.
- R3: For op 1, `y = a_in - b_in - (1 - c_in)` modulo 256, and C is set when no borrow occurred. V is set when the operands differ in bit 7 and `y[7]` differs from `a_in[7]`. H is the inverse of bit 4 of `a_in ^ b_in ^ y`.
- R4: For op 2, `y` shows `a_in - b_in` (no carry-in) but `y_we` is 0. Only N, Z and C are written, with C set when `a_in >= b_in`.
- R5: For ops 3, 4 and 5, `y` is the AND, OR or XOR of the operands, and only N and Z are written.
- R6: Op 6 shifts left with 0 into bit 0, and op 7 shifts right with 0 into bit 7. Op 8 rotates left with `c_in` into bit 0, and op 9 rotates right with `c_in` into bit 7. In all four, C takes the bit shifted out, and only N, Z and C are written.
- R7: Ops 10 and 11 add or subtract one modulo 256 and write only N and Z.
- R8: Op 12 exchanges the two nibbles of `a_in` and writes only N and Z.
- R9: Op 13 works in two steps and writes N, Z and C.
  - Step one: if the low nibble of `a_in` exceeds 9 or `h_in` is 1, add 0x06, and count carry as set if `a_in` exceeds 0xF0.
  - Step two: if the step-one value exceeds 0x9F or carry is set (`c_in` or the step-one carry), add 0x60 and set C; otherwise clear C.
- R10: Op 14 works in two steps and writes N, Z and C.
  - Step one: if the low nibble of `a_in` exceeds 9 or `h_in` is 0, subtract 0x06.
  - Step two: if that value exceeds 0x9F or `c_in` is 0, subtract 0x60 and clear C; otherwise set C.
- R11: Whenever Z is written it is 1 exactly when `y` is 0x00, and whenever N is written it equals `y[7]`.
- R12: Op 15 has no effect: all six write-enables are 0 and `y` equals `a_in`.
- R13: A flag whose write-enable is 0 is driven 0. `y_we` is 1 for every op except 2 and 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | first operand, and the only operand of single-operand ops |
| b_in | input | 8 | second operand |
| op | input | 4 | operation code |
| c_in | input | 1 | current carry flag |
| h_in | input | 1 | current half-carry flag |
| y | output | 8 | result |
| y_we | output | 1 | result write-enable |
| n_we | output | 1 | N write-enable |
| v_we | output | 1 | V write-enable |
| h_we | output | 1 | H write-enable |
| z_we | output | 1 | Z write-enable |
| c_we | output | 1 | C write-enable |
| n | output | 1 | next negative flag |
| v | output | 1 | next overflow flag |
| h | output | 1 | next half-carry flag |
| z | output | 1 | next zero flag |
| c | output | 1 | next carry flag |

## Verification
The hardest corners are in decimal adjust after addition. One is an operand above 0xF0 that wraps in the first step and must still produce carry. Another is the second step firing only because of the carry-in. Each depends on a particular mix of low nibble, half-carry and carry that ordinary arithmetic seldom produces.

The stimulus drives every operand value with carry and half-carry varied directly, so these mixes appear without any preceding addition. Hand-picked vectors pin the known edges, and an exhaustive sweep of all operand pairs compares every operation against an independent model.

// File: rtl/alu8_flags.sv
`timescale 1ns/1ps
module alu8_flags (
  input  logic [7:0] a_in,
  input  logic [7:0] b_in,
  input  logic [3:0] op,
  input  logic       c_in,
  input  logic       h_in,
  output logic [7:0] y,
  output logic       y_we,
  output logic       n_we,
  output logic       v_we,
  output logic       h_we,
  output logic       z_we,
  output logic       c_we,
  output logic       n,
  output logic       v,
  output logic       h,
  output logic       z,
  output logic       c
);
  localparam logic [3:0] OP_ADC = 4'd0,  OP_SBC = 4'd1,  OP_CMP = 4'd2,  OP_AND = 4'd3,
                         OP_OR  = 4'd4,  OP_XOR = 4'd5,  OP_ASL = 4'd6,  OP_LSR = 4'd7,
                         OP_ROL = 4'd8,  OP_ROR = 4'd9,  OP_INC = 4'd10, OP_DEC = 4'd11,
                         OP_XCN = 4'd12, OP_DAA = 4'd13, OP_DAS = 4'd14;

  logic [8:0] sum9, dif9, cmp9;
  logic [7:0] step;
  logic       lo_fix, dec_c, fv, fh, fc;

  assign sum9 = {1'b0, a_in} + {1'b0, b_in} + {8'd0, c_in};
  assign dif9 = {1'b0, a_in} - {1'b0, b_in} - {8'd0, ~c_in};
  assign cmp9 = {1'b0, a_in} - {1'b0, b_in};

  always_comb begin
    y      = a_in;
    y_we   = 1'b0;
    n_we   = 1'b0;
    v_we   = 1'b0;
    h_we   = 1'b0;
    z_we   = 1'b0;
    c_we   = 1'b0;
    fv     = 1'b0;
    fh     = 1'b0;
    fc     = 1'b0;
    step   = a_in;
    lo_fix = 1'b0;
    dec_c  = c_in;
    case (op)
      OP_ADC: begin
        y = sum9[7:0];
        fc = sum9[8];
        fv = (a_in[7] == b_in[7]) && (sum9[7] != a_in[7]);
        fh = a_in[4] ^ b_in[4] ^ sum9[4];
        {y_we, n_we, v_we, h_we, z_we, c_we} = 6'b111111;
      end
      OP_SBC: begin
        y = dif9[7:0];
        fc = ~dif9[8];
        fv = (a_in[7] != b_in[7]) && (dif9[7] != a_in[7]);
        fh = ~(a_in[4] ^ b_in[4] ^ dif9[4]);
        {y_we, n_we, v_we, h_we, z_we, c_we} = 6'b111111;
      end
      OP_CMP: begin
        y = cmp9[7:0];
        fc = ~cmp9[8];
        {n_we, z_we, c_we} = 3'b111;
      end
      OP_AND, OP_OR, OP_XOR: begin
        y = (op == OP_AND) ? (a_in & b_in) : (op == OP_OR) ? (a_in | b_in) : (a_in ^ b_in);
        {y_we, n_we, z_we} = 3'b111;
      end
      OP_ASL, OP_ROL: begin
        y = {a_in[6:0], (op == OP_ROL) & c_in};
        fc = a_in[7];
        {y_we, n_we, z_we, c_we} = 4'b1111;
      end
      OP_LSR, OP_ROR: begin
        y = {(op == OP_ROR) & c_in, a_in[7:1]};
        fc = a_in[0];
        {y_we, n_we, z_we, c_we} = 4'b1111;
      end
      OP_INC, OP_DEC: begin
        y = (op == OP_INC) ? a_in + 8'd1 : a_in - 8'd1;
        {y_we, n_we, z_we} = 3'b111;
      end
      OP_XCN: begin
        y = {a_in[3:0], a_in[7:4]};
        {y_we, n_we, z_we} = 3'b111;
      end
      OP_DAA: begin
        lo_fix = (a_in[3:0] > 4'd9) || h_in;
        step   = lo_fix ? a_in + 8'h06 : a_in;
        dec_c  = c_in || (lo_fix && (a_in > 8'hF0));
        fc     = (step > 8'h9F) || dec_c;
        y      = fc ? step + 8'h60 : step;
        {y_we, n_we, z_we, c_we} = 4'b1111;
      end
      OP_DAS: begin
        lo_fix = (a_in[3:0] > 4'd9) || !h_in;
        step   = lo_fix ? a_in - 8'h06 : a_in;
        fc     = !((step > 8'h9F) || !c_in);
        y      = fc ? step : step - 8'h60;
        {y_we, n_we, z_we, c_we} = 4'b1111;
      end
      default: ;
    endcase
  end

  assign n = n_we & y[7];
  assign z = z_we & (y == 8'h00);
  assign v = v_we & fv;
  assign h = h_we & fh;
  assign c = c_we & fc;
endmodule

// File: rtl/alu8_flags_chk.sv
`timescale 1ns/1ps
module alu8_flags_chk (
  input logic [7:0] a_in,
  input logic [7:0] b_in,
  input logic [3:0] op,
  input logic       c_in,
  input logic [7:0] y,
  input logic       y_we,
  input logic       n_we,
  input logic       v_we,
  input logic       h_we,
  input logic       z_we,
  input logic       c_we,
  input logic       n,
  input logic       v,
  input logic       h,
  input logic       z,
  input logic       c
);
  always_comb begin
    p_zero_tracks_result_r11: assert (!z_we || (z == (y == 8'h00)));
    p_neg_tracks_result_r11:  assert (!n_we || (n == y[7]));
    p_quiet_flags_r13: assert ((v_we || !v) && (h_we || !h) && (c_we || !c) && (n_we || !n) && (z_we || !z));
    if (op == 4'd15)
      p_nop_no_effect_r12: assert (!y_we && !n_we && !v_we && !h_we && !z_we && !c_we && (y == a_in));
    if (op == 4'd2)
      p_cmp_no_write_r4: assert (!y_we && !v_we && !h_we && c_we && (c == (a_in >= b_in)));
    if (op == 4'd0)
      p_adc_sum_r1: assert ({c, y} == (9'(a_in) + 9'(b_in) + 9'(c_in)));
    if (op == 4'd8)
      p_rol_through_carry_r6: assert ((y[0] == c_in) && (c == a_in[7]) && (y[7:1] == a_in[6:0]));
  end
endmodule

bind alu8_flags alu8_flags_chk i_chk (
  .a_in(a_in), .b_in(b_in), .op(op), .c_in(c_in), .y(y), .y_we(y_we),
  .n_we(n_we), .v_we(v_we), .h_we(h_we), .z_we(z_we), .c_we(c_we),
  .n(n), .v(v), .h(h), .z(z), .c(c)
);

// File: tb/test_alu8_flags.sv
`timescale 1ns/1ps
module test_alu8_flags;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] a_in, b_in, y;
  logic [3:0] op;
  logic c_in, h_in, y_we, n_we, v_we, h_we, z_we, c_we, n, v, h, z, c;
  int tests = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  alu8_flags i_alu8_flags (.a_in(a_in), .b_in(b_in), .op(op), .c_in(c_in), .h_in(h_in),
    .y(y), .y_we(y_we), .n_we(n_we), .v_we(v_we), .h_we(h_we), .z_we(z_we), .c_we(c_we),
    .n(n), .v(v), .h(h), .z(z), .c(c));

  wire [18:0] got = {y, y_we, n_we, v_we, h_we, z_we, c_we, n, v, h, z, c};

  // fields: op, a, b, c_in, h_in, expected y, expected {n,v,h,z,c}
  localparam int NV = 24;
  localparam logic [34:0] VEC [NV] = '{
    {4'd0,  8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 5'b11100},  // R2 signed overflow, half carry
    {4'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 5'b00111},  // R1 carry out
    {4'd0,  8'h00, 8'h00, 1'b1, 1'b0, 8'h01, 5'b00000},  // R1 carry in
    {4'd1,  8'h80, 8'h01, 1'b1, 1'b0, 8'h7F, 5'b01001},  // R3 overflow
    {4'd1,  8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 5'b10000},  // R3 borrow
    {4'd1,  8'h15, 8'h03, 1'b1, 1'b0, 8'h12, 5'b00101},  // R3 inverted half carry
    {4'd2,  8'h05, 8'h05, 1'b0, 1'b0, 8'h00, 5'b00011},  // R4 equal
    {4'd2,  8'h04, 8'h05, 1'b1, 1'b0, 8'hFF, 5'b10000},  // R4 less, carry-in ignored
    {4'd3,  8'hF0, 8'h3C, 1'b1, 1'b1, 8'h30, 5'b00000},  // R5
    {4'd4,  8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 5'b00010},  // R5
    {4'd5,  8'hAA, 8'h55, 1'b0, 1'b0, 8'hFF, 5'b10000},  // R5
    {4'd6,  8'h81, 8'h00, 1'b0, 1'b0, 8'h02, 5'b00001},  // R6
    {4'd7,  8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 5'b00011},  // R6
    {4'd8,  8'h80, 8'h00, 1'b1, 1'b0, 8'h01, 5'b00001},  // R6
    {4'd9,  8'h01, 8'h00, 1'b1, 1'b0, 8'h80, 5'b10001},  // R6
    {4'd10, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 5'b00010},  // R7
    {4'd11, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 5'b10000},  // R7
    {4'd12, 8'h1E, 8'h00, 1'b0, 1'b0, 8'hE1, 5'b10000},  // R8
    {4'd13, 8'h1A, 8'h00, 1'b0, 1'b0, 8'h20, 5'b00000},  // R9 low fix only
    {4'd13, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 5'b00011},  // R9 both steps
    {4'd13, 8'hFA, 8'h00, 1'b0, 1'b0, 8'h60, 5'b00001},  // R9 wrap sets carry
    {4'd14, 8'h1F, 8'h00, 1'b1, 1'b0, 8'h19, 5'b00001},  // R10 low fix only
    {4'd14, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h99, 5'b10000},  // R10 both steps
    {4'd15, 8'h3C, 8'h77, 1'b1, 1'b1, 8'h3C, 5'b00000}   // R12 no effect
  };

  function automatic logic [18:0] model(int o, int a, int b, int ci, int hi);
    int r, t;
    bit yw, nw, vw, hw, zw, cw, fv, fh, fc, k;
    r = a; yw = 0; nw = 0; vw = 0; hw = 0; zw = 0; cw = 0; fv = 0; fh = 0; fc = 0;
    case (o)
      0: begin r = a + b + ci; fc = r >= 256; r = r & 255;
           fv = ((a >= 128) == (b >= 128)) && ((r >= 128) != (a >= 128));
           fh = ((a ^ b ^ r) >> 4) & 1; {yw, nw, vw, hw, zw, cw} = 6'h3F; end
      1: begin r = a - b + ci - 1; fc = r >= 0; r = r & 255;
           fv = ((a >= 128) != (b >= 128)) && ((r >= 128) != (a >= 128));
           fh = !(((a ^ b ^ r) >> 4) & 1); {yw, nw, vw, hw, zw, cw} = 6'h3F; end
      2: begin r = (a - b) & 255; fc = a >= b; {nw, zw, cw} = 3'b111; end
      3: begin r = a & b; {yw, nw, zw} = 3'b111; end
      4: begin r = a | b; {yw, nw, zw} = 3'b111; end
      5: begin r = a ^ b; {yw, nw, zw} = 3'b111; end
      6: begin r = (a * 2) & 255; fc = a >= 128; {yw, nw, zw, cw} = 4'hF; end
      7: begin r = a / 2; fc = a % 2; {yw, nw, zw, cw} = 4'hF; end
      8: begin r = (a * 2 + ci) & 255; fc = a >= 128; {yw, nw, zw, cw} = 4'hF; end
      9: begin r = a / 2 + ci * 128; fc = a % 2; {yw, nw, zw, cw} = 4'hF; end
      10: begin r = (a + 1) & 255; {yw, nw, zw} = 3'b111; end
      11: begin r = (a + 255) & 255; {yw, nw, zw} = 3'b111; end
      12: begin r = (a % 16) * 16 + a / 16; {yw, nw, zw} = 3'b111; end
      13: begin t = a; k = ci != 0;
            if (a % 16 > 9 || hi != 0) begin if (a > 240) k = 1; t = (a + 6) & 255; end
            if (t > 159 || k) begin t = (t + 96) & 255; fc = 1; end
            r = t; {yw, nw, zw, cw} = 4'hF; end
      14: begin t = a;
            if (a % 16 > 9 || hi == 0) t = (a + 250) & 255;
            if (t > 159 || ci == 0) t = (t + 160) & 255; else fc = 1;
            r = t; {yw, nw, zw, cw} = 4'hF; end
      default: ;
    endcase
    return {8'(r), yw, nw, vw, hw, zw, cw, nw && r >= 128, vw && fv, hw && fh, zw && r == 0, cw && fc};
  endfunction

  task automatic check(input string req, input logic [18:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h c=%0b h=%0b actual=%h expected=%h",
               req, op, a_in, b_in, c_in, h_in, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    op = 4'd0; a_in = 8'h00; b_in = 8'h00; c_in = 1'b0; h_in = 1'b0;
    @(negedge clk);
    check("R11 idle inputs", {8'h00, 6'h3F, 5'b00010});

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op, a_in, b_in, c_in, h_in} = VEC[i][34:13];
      #1;
      tests++;
      if ({y, n, v, h, z, c} !== VEC[i][12:0]) begin
        fails++;
        $display("FAIL vector %0d (R1..R12 table) actual=%h expected=%h", i, {y, n, v, h, z, c}, VEC[i][12:0]);
      end
      check("R13 vector vs model", model(VEC[i][34:31], VEC[i][30:23], VEC[i][22:15], VEC[i][14], VEC[i][13]));
    end

    // R9 R10 h_in toggled directly, R12 with every operand, R13 write-enables
    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          for (int ci = 0; ci < 2; ci++) begin
            op = 4'(o); a_in = 8'(a); b_in = 8'(b); c_in = ci[0]; h_in = b[1] ^ ci[0];
            #0.01;
            check("R1-sweep R3 R13", model(o, a, b, ci, b[1] ^ ci[0]));
          end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule